// File: doc/BRIEF.md
# Prioritized Interrupt Level Controller

This block collects request lines from up to seven interrupt sources and reduces them to a single priority level. The level is shown on three active-low pins. The block compares that level with the three-bit interrupt mask kept in bits 8 to 10 of the processor status word. When a level passes the mask, the block records the level as the new mask and opens an acknowledge cycle for that level. It then returns one vector number per accepted interrupt.

The vector number comes from one of three places. Normally the answering device supplies it. A device that answers but has not been configured yet yields the fixed uninitialized vector 0x0F. If nothing answers within a fixed number of clocks, the block stops waiting and returns spurious vector 24. Level 7 cannot be masked: a new arrival at level 7 is accepted even when the mask is 7. It is accepted once per arrival, so a held level 7 request does not retrigger endlessly.

Top module: `irq_level_ctrl`

## Requirements
- R1: `iplN` is the bitwise inverse of the encoded request level. It follows a change on `devReq` one clock edge later, and is 3'b111 when no line is active.
- R2: Request bit k of `devReq` stands for level k+1. When several bits are set, the highest set bit decides the level.
- R3: Outside an acknowledge cycle, a level from 1 to 6 is accepted only if it is strictly greater than the mask. A level at or below the mask never starts an acknowledge cycle. Level 0 is never accepted.
- R4: Level 7 is accepted with any mask, including 7, once per rise of the encoded level to 7. While level 7 stays held with the mask at 7, it is not accepted again.
- R5: On acceptance, one clock edge after the encoded level is seen, `iackActive` rises, `iackLevel` carries the accepted level, and `maskOut` takes that level.
- R6: During an acknowledge cycle, a device answer (`respValid` high with `respUninit` low) ends the cycle. On the next edge `vecValid` pulses for one cycle with `vecNum` equal to `respVec`.
- R7: A device answer with `respUninit` high gives `vecNum` = 0x0F, whatever `respVec` holds.
- R8: If no answer arrives, `iackActive` stays high for exactly TIMEOUT cycles (16 by default). In the cycle after it drops, `vecValid` pulses with `vecNum` = 24.
- R9: `respValid` has no effect outside an acknowledge cycle: `vecValid` stays low.
- R10: While reset is held and after it is released: `iplN` = 3'b111, `maskOut` = 7, `iackActive` = 0 and `vecValid` = 0.
- R11: Outside an acceptance, `maskLoad` writes `maskData` into the mask on the next edge. An acceptance in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| devReq | input | 7 | Request lines, bit k is level k+1 |
| maskLoad | input | 1 | Write strobe for the mask field |
| maskData | input | 3 | New mask value |
| respValid | input | 1 | A device answers the acknowledge |
| respUninit | input | 1 | The answering device is not configured |
| respVec | input | 8 | Vector number supplied by the device |
| iplN | output | 3 | Active-low encoded priority level |
| maskOut | output | 3 | Current mask field |
| iackActive | output | 1 | Acknowledge cycle in progress |
| iackLevel | output | 3 | Level being acknowledged |
| vecValid | output | 1 | One-cycle strobe: vector ready |
| vecNum | output | 8 | Returned vector number |

## Verification
A change on the request lines reaches `iplN` after one edge. It starts an acknowledge cycle after a second edge, which updates `iackActive`, `iackLevel` and `maskOut` together. A device answer reaches `vecValid` and `vecNum` one edge after it is driven. A silent device produces the spurious vector exactly TIMEOUT cycles after `iackActive` is first seen. The bench drives inputs and samples outputs on falling edges and counts those edges between stimulus and check. The timeout case counts cycles until the strobe arrives and compares the count with TIMEOUT.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic take;     // accept the current level
    logic cntClr;   // clear acknowledge timer
    logic cntInc;   // advance acknowledge timer
    logic vecDev;   // load vector from device answer
    logic vecSpur;  // load spurious vector
  } ctrlStrb_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_ACK = 1'b1} ackState_t;
endpackage

// File: rtl/irq_lvl_dp.sv
module irq_lvl_dp
  import irq_lvl_pkg::*;
#(
  parameter int LVL_W = 3,
  parameter int VEC_W = 8,
  parameter int TIMEOUT = 16,
  parameter logic [VEC_W-1:0] UNINIT_VEC = 8'h0F,
  parameter logic [VEC_W-1:0] SPUR_VEC = 8'd24
) (
  input  logic clk,
  input  logic rstN,
  input  logic [(2**LVL_W)-2:0] devReq,
  input  logic maskLoad,
  input  logic [LVL_W-1:0] maskData,
  input  logic respUninit,
  input  logic [VEC_W-1:0] respVec,
  input  ctrlStrb_t strb,
  output logic accept,
  output logic timeoutHit,
  output logic [LVL_W-1:0] iplN,
  output logic [LVL_W-1:0] maskOut,
  output logic [LVL_W-1:0] iackLevel,
  output logic vecValid,
  output logic [VEC_W-1:0] vecNum
);
  localparam int NUM_REQ = (2**LVL_W) - 1;
  localparam int CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [LVL_W-1:0] TOP_LVL = {LVL_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

  logic [LVL_W-1:0] encLvl, levelQ, prevLvlQ, maskQ, ackLvlQ;
  logic nmiPendQ, nmiEdge;
  logic [CNT_W-1:0] cntQ;
  logic [VEC_W-1:0] vecQ;
  logic vecValidQ;

  // priority encoder: highest set request wins
  always_comb begin
    encLvl = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (devReq[i]) encLvl = LVL_W'(i + 1);
    end
  end

  assign nmiEdge = (levelQ == TOP_LVL) && (prevLvlQ != TOP_LVL);
  assign accept = (levelQ > maskQ) ||
                  ((levelQ == TOP_LVL) && (nmiPendQ || nmiEdge));
  assign timeoutHit = (cntQ == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ <= '0;
      prevLvlQ <= '0;
      nmiPendQ <= 1'b0;
      maskQ <= TOP_LVL;
      ackLvlQ <= '0;
    end else begin
      levelQ <= encLvl;
      prevLvlQ <= levelQ;
      if (strb.take && levelQ == TOP_LVL) nmiPendQ <= 1'b0;
      else if (nmiEdge) nmiPendQ <= 1'b1;
      if (strb.take) begin
        maskQ <= levelQ;
        ackLvlQ <= levelQ;
      end else if (maskLoad) begin
        maskQ <= maskData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      vecQ <= '0;
      vecValidQ <= 1'b0;
    end else begin
      if (strb.cntClr) cntQ <= '0;
      else if (strb.cntInc) cntQ <= cntQ + 1'b1;
      vecValidQ <= strb.vecDev || strb.vecSpur;
      if (strb.vecDev) vecQ <= respUninit ? UNINIT_VEC : respVec;
      else if (strb.vecSpur) vecQ <= SPUR_VEC;
    end
  end

  assign iplN = ~levelQ;
  assign maskOut = maskQ;
  assign iackLevel = ackLvlQ;
  assign vecValid = vecValidQ;
  assign vecNum = vecQ;

  // R5: the mask takes the accepted level
  p_mask_raise_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |=> maskQ == $past(levelQ));
  // R3 / R4: acceptance only above mask or at the top level
  p_accept_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |-> ((levelQ > maskQ) || (levelQ == TOP_LVL)));
  // R8: timer never runs past its last count
  p_timer_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CNT_LAST);
  // R6: vector strobe lasts a single cycle
  p_vec_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    vecValidQ |=> !vecValidQ);
endmodule

// File: rtl/irq_lvl_ctrl.sv
module irq_lvl_ctrl
  import irq_lvl_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic accept,
  input  logic respValid,
  input  logic timeoutHit,
  output ctrlStrb_t strb,
  output logic iackActive
);
  ackState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strb = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (accept) begin
          strb.take = 1'b1;
          strb.cntClr = 1'b1;
          stateD = ST_ACK;
        end
      end
      ST_ACK: begin
        if (respValid) begin
          strb.vecDev = 1'b1;
          stateD = ST_IDLE;
        end else if (timeoutHit) begin
          strb.vecSpur = 1'b1;
          stateD = ST_IDLE;
        end else begin
          strb.cntInc = 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else stateQ <= stateD;
  end

  assign iackActive = (stateQ == ST_ACK);

  // R5: an acknowledge cycle only opens after an accepted level
  p_ack_open_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(iackActive) |-> $past(accept));
  // R9: a vector is only produced while acknowledging
  p_vec_in_ack_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.vecDev || strb.vecSpur) |=> !iackActive);
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_lvl_pkg::*;
#(
  parameter int LVL_W = 3,
  parameter int VEC_W = 8,
  parameter int TIMEOUT = 16,
  parameter logic [VEC_W-1:0] UNINIT_VEC = 8'h0F,
  parameter logic [VEC_W-1:0] SPUR_VEC = 8'd24
) (
  input  logic clk,
  input  logic rstN,
  input  logic [(2**LVL_W)-2:0] devReq,
  input  logic maskLoad,
  input  logic [LVL_W-1:0] maskData,
  input  logic respValid,
  input  logic respUninit,
  input  logic [VEC_W-1:0] respVec,
  output logic [LVL_W-1:0] iplN,
  output logic [LVL_W-1:0] maskOut,
  output logic iackActive,
  output logic [LVL_W-1:0] iackLevel,
  output logic vecValid,
  output logic [VEC_W-1:0] vecNum
);
  ctrlStrb_t strb;
  logic accept, timeoutHit;

  irq_lvl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .accept(accept), .respValid(respValid),
    .timeoutHit(timeoutHit), .strb(strb), .iackActive(iackActive)
  );

  irq_lvl_dp #(
    .LVL_W(LVL_W), .VEC_W(VEC_W), .TIMEOUT(TIMEOUT),
    .UNINIT_VEC(UNINIT_VEC), .SPUR_VEC(SPUR_VEC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .devReq(devReq), .maskLoad(maskLoad),
    .maskData(maskData), .respUninit(respUninit), .respVec(respVec),
    .strb(strb), .accept(accept), .timeoutHit(timeoutHit), .iplN(iplN),
    .maskOut(maskOut), .iackLevel(iackLevel), .vecValid(vecValid),
    .vecNum(vecNum)
  );
endmodule

// File: tb/irq_level_ctrl_tb.sv
`timescale 1ns/1ps
module irq_level_ctrl_tb;
  localparam int TIMEOUT = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [6:0] devReq = '0;
  logic maskLoad = 1'b0;
  logic [2:0] maskData = '0;
  logic respValid = 1'b0;
  logic respUninit = 1'b0;
  logic [7:0] respVec = '0;
  logic [2:0] iplN, maskOut, iackLevel;
  logic iackActive, vecValid;
  logic [7:0] vecNum;

  int nTests = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_level_ctrl #(.TIMEOUT(TIMEOUT)) u_dut (
    .clk(clk), .rstN(rstN), .devReq(devReq), .maskLoad(maskLoad),
    .maskData(maskData), .respValid(respValid), .respUninit(respUninit),
    .respVec(respVec), .iplN(iplN), .maskOut(maskOut),
    .iackActive(iackActive), .iackLevel(iackLevel), .vecValid(vecValid),
    .vecNum(vecNum)
  );

  // {devReq, expected iplN}
  localparam logic [9:0] VECS [8] = '{
    {7'b0000000, 3'b111}, {7'b0000001, 3'b110}, {7'b0000011, 3'b101},
    {7'b0000100, 3'b100}, {7'b0001010, 3'b011}, {7'b0010001, 3'b010},
    {7'b0101000, 3'b001}, {7'b0011111, 3'b010}
  };

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  initial begin
    int cycles;
    step(2);
    // R10 reset state
    check("R10 iplN", iplN, 3'b111);
    check("R10 mask", maskOut, 7);
    check("R10 iack", iackActive, 0);
    check("R10 vecValid", vecValid, 0);
    rstN = 1'b1;
    step(2);
    check("R10 mask after release", maskOut, 7);

    // R1 / R2 table, mask 7 keeps levels 1..6 out
    foreach (VECS[i]) begin
      devReq = VECS[i][9:3];
      step();
      check("R1/R2 iplN", iplN, VECS[i][2:0]);
    end
    check("R3 no ack with mask 7", iackActive, 0);
    devReq = '0;
    step();

    // R11 mask load
    maskLoad = 1'b1; maskData = 3'd3;
    step();
    maskLoad = 1'b0;
    check("R11 mask load", maskOut, 3);

    // R3 level equal to mask rejected
    devReq = 7'b0000100;
    step(4);
    check("R3 level 3 vs mask 3", iackActive, 0);

    // R5 / R6 level 5 accepted, device answers
    devReq = 7'b0010100;
    step(2);
    check("R5 iack", iackActive, 1);
    check("R5 iackLevel", iackLevel, 5);
    check("R5 mask raised", maskOut, 5);
    respValid = 1'b1; respVec = 8'h40;
    step();
    respValid = 1'b0;
    check("R6 vecValid", vecValid, 1);
    check("R6 vecNum", vecNum, 8'h40);
    step();
    check("R6 single pulse", vecValid, 0);
    step(3);
    check("R3 held level 5 vs mask 5", iackActive, 0);

    // R7 level 6, uninitialized device
    devReq = 7'b0100000;
    step(2);
    check("R7 iackLevel", iackLevel, 6);
    respValid = 1'b1; respUninit = 1'b1; respVec = 8'hAA;
    step();
    respValid = 1'b0; respUninit = 1'b0;
    check("R7 vecValid", vecValid, 1);
    check("R7 vecNum", vecNum, 8'h0F);

    // R4 / R8 level 7 with mask 7, no answer
    devReq = '0;
    maskLoad = 1'b1; maskData = 3'd7;
    step();
    maskLoad = 1'b0;
    check("R11 mask 7", maskOut, 7);
    devReq = 7'b1000000;
    step();
    check("R1 level 7 iplN", iplN, 0);
    step();
    check("R4 nmi accepted", iackActive, 1);
    check("R4 iackLevel", iackLevel, 7);
    cycles = 0;
    while (!vecValid && cycles < 100) begin
      step();
      cycles++;
    end
    check("R8 timeout cycles", cycles, TIMEOUT);
    check("R8 spurious vector", vecNum, 24);
    step(5);
    check("R4 held level 7 not retaken", iackActive, 0);

    // R4 new rise is accepted again
    devReq = '0;
    step(2);
    devReq = 7'b1000001;
    step(2);
    check("R4 second rise accepted", iackActive, 1);
    respValid = 1'b1; respVec = 8'h55;
    step();
    respValid = 1'b0;
    check("R6 nmi vecNum", vecNum, 8'h55);

    // R9 answer outside acknowledge ignored
    step(2);
    respValid = 1'b1; respVec = 8'h33;
    for (int k = 0; k < 3; k++) begin
      step();
      check("R9 no vector when idle", vecValid, 0);
    end
    respValid = 1'b0;

    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      nTests++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end
endmodule